// File: doc/BRIEF.md
# Ring-Rotated Priority Arbiter for Sixteen Streams

This block picks, every cycle, one stream to fetch for and one stream to execute from, out of sixteen hardware streams. Priority rotates without a barrel shifter. The status of each stream is kept in a ring of sixteen slots. Two fixed priority encoders scan that ring, and the highest-numbered slot always wins. To rotate priority, every slot passes its contents one step around the ring while a rotation counter advances. Two small adders then add the counter to the encoder outputs, which turns the winning slot numbers back into real stream numbers.

On a normal cycle each slot loads the current request and halt inputs of the stream that maps onto it. On a rotation cycle the inputs are not sampled and the contents only move. A rotation happens for one of two reasons:
- the slot with the highest priority holds a halted stream, so the ring skips past streams that cannot use their share; or
- a periodic quantum tick arrives, so that the top priority walks through all the streams over time.

At most one rotation happens in any two consecutive cycles.

Top module: `rot_ring_arbiter`

## Requirements
- R1: After reset the rotation count is 0 and neither grant is valid until requests have been sampled.
- R2: The fetch grant names the requesting, non-halted stream whose slot is highest. Slot p holds stream (p + count) mod 16, so slot 15 holds the top stream. The grant reflects the inputs sampled at the previous clock edge. With count 0 the highest-numbered requesting stream wins.
- R3: The execute grant uses the same slot order but its own request bits, independently of the fetch grant.
- R4: A stream whose halt input was sampled high is never granted, on either output, even when it requests.
- R5: When slot 15 holds a halted stream and the previous cycle did not rotate, the ring rotates by one. Afterwards the next stream in ascending order (modulo 16) holds top priority.
- R6: Two rotations never happen in consecutive cycles. A run of k halted streams at the top therefore takes 2k-1 cycles after the first load to skip over.
- R7: A quantum tick is held until a rotation happens on a later cycle, and it causes exactly one rotation at the first cycle that allows one. Each tick therefore moves top priority forward by one stream.
- R8: Each rotation adds 1 to the count, modulo 16. On a rotation, slot p takes the contents of slot p+1, and slot 15 takes the contents of slot 0.
- R9: On a rotation cycle the request and halt inputs are ignored. Input changes made during that cycle take effect at the next non-rotating cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 16 | Per-stream fetch request, bit i for stream i |
| execReq | input | 16 | Per-stream execute request, bit i for stream i |
| haltIn | input | 16 | Per-stream halted flag, bit i for stream i |
| quantumTick | input | 1 | One-cycle pulse asking for a priority rotation |
| fetchValid | output | 1 | Fetch grant present |
| fetchStream | output | 4 | Stream number of the fetch grant |
| execValid | output | 1 | Execute grant present |
| execStream | output | 4 | Stream number of the execute grant |

## Verification
Some properties are checked by assertions on every cycle:
- rotations are spaced at least one cycle apart;
- the count steps by exactly one on each rotation and holds otherwise;
- a halted top slot or a quantum tick is followed by a rotation;
- a granted slot really holds a live request;
- a live request in the top slot always wins.

Other behaviour can only be shown by the bench's scenarios at the ports:
- the full slot-to-stream mapping after several rotations;
- the cycle-by-cycle progress of skipping three halted streams;
- the deferral of input changes made during a rotation.

// File: rtl/ringarb_pkg.sv
package ringarb_pkg;

  // Contents of one ring slot.
  typedef struct packed {
    logic halt;
    logic fetch;
    logic exec;
  } statElem_t;

  // Control-to-datapath strobes: exactly one is high each cycle.
  typedef struct packed {
    logic rotate;
    logic load;
  } ringStrobe_t;

endpackage

// File: rtl/ringarb_prio_enc.sv
module ringarb_prio_enc #(
  parameter int WIDTH = 16,
  parameter int IW    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic             anyReq,
  output logic [IW-1:0]    topPos
);

  // Fixed priority: the highest set position wins.
  always_comb begin
    anyReq = 1'b0;
    topPos = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (reqVec[i]) begin
        anyReq = 1'b1;
        topPos = IW'(i);
      end
    end
  end

endmodule

// File: rtl/ringarb_ctrl.sv
module ringarb_ctrl
  import ringarb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        quantumTick,
  input  logic        topHalted,
  output ringStrobe_t strobe
);

  logic rotLast;
  logic tickPend;
  logic rotateNow;

  // Rotate only if the previous cycle did not, and there is a reason to.
  assign rotateNow     = !rotLast && (topHalted || tickPend);
  assign strobe.rotate = rotateNow;
  assign strobe.load   = !rotateNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotLast  <= 1'b0;
      tickPend <= 1'b0;
    end else begin
      rotLast  <= rotateNow;
      tickPend <= quantumTick | (tickPend & !rotateNow);
    end
  end

  AST_ROT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rotate |=> !strobe.rotate); // R6

  AST_TICK_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    quantumTick |=> (strobe.rotate || $past(strobe.rotate))); // R7

endmodule

// File: rtl/ringarb_ring.sv
module ringarb_ring
  import ringarb_pkg::*;
#(
  parameter int NUM = 16,
  parameter int IW  = $clog2(NUM)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ringStrobe_t     strobe,
  input  logic [NUM-1:0]  fetchReqIn,
  input  logic [NUM-1:0]  execReqIn,
  input  logic [NUM-1:0]  haltIn,
  output logic            fetchValid,
  output logic [IW-1:0]   fetchStream,
  output logic            execValid,
  output logic [IW-1:0]   execStream,
  output logic            topHalted,
  output logic [IW-1:0]   rotCount
);

  statElem_t         ring [NUM];
  logic [IW-1:0]     rotCnt;
  logic [NUM-1:0]    fetchVec;
  logic [NUM-1:0]    execVec;
  logic [IW-1:0]     fetchPos;
  logic [IW-1:0]     execPos;

  for (genvar p = 0; p < NUM; p++) begin : g_slot
    logic [IW-1:0] srcIdx;
    // Slot p maps to stream p + count (mod NUM).
    assign srcIdx = IW'(p) + rotCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ring[p] <= '0;
      end else if (strobe.rotate) begin
        ring[p] <= ring[(p + 1) % NUM];
      end else if (strobe.load) begin
        ring[p] <= '{halt: haltIn[srcIdx], fetch: fetchReqIn[srcIdx],
                     exec: execReqIn[srcIdx]};
      end
    end

    assign fetchVec[p] = ring[p].fetch && !ring[p].halt;
    assign execVec[p]  = ring[p].exec  && !ring[p].halt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rotCnt <= '0;
    else if (strobe.rotate) rotCnt <= rotCnt + 1'b1;
  end

  ringarb_prio_enc #(.WIDTH(NUM), .IW(IW)) u_fetchEnc (
    .reqVec (fetchVec),
    .anyReq (fetchValid),
    .topPos (fetchPos)
  );

  ringarb_prio_enc #(.WIDTH(NUM), .IW(IW)) u_execEnc (
    .reqVec (execVec),
    .anyReq (execValid),
    .topPos (execPos)
  );

  // Adders recover the real stream number from the winning slot.
  assign fetchStream = fetchPos + rotCnt;
  assign execStream  = execPos + rotCnt;
  assign topHalted   = ring[NUM-1].halt;
  assign rotCount    = rotCnt;

  logic [IW-1:0] fetchBack;
  logic [IW-1:0] execBack;
  assign fetchBack = fetchStream - rotCnt;
  assign execBack  = execStream - rotCnt;

  AST_FETCH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (ring[fetchBack].fetch && !ring[fetchBack].halt)); // R4

  AST_EXEC_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> (ring[execBack].exec && !ring[execBack].halt)); // R4

  AST_TOP_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (ring[NUM-1].fetch && !ring[NUM-1].halt)
      |-> (fetchValid && fetchStream == IW'(rotCnt + IW'(NUM-1)))); // R2

  AST_TOP_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (ring[NUM-1].exec && !ring[NUM-1].halt)
      |-> (execValid && execStream == IW'(rotCnt + IW'(NUM-1)))); // R3

endmodule

// File: rtl/rot_ring_arbiter.sv
module rot_ring_arbiter
  import ringarb_pkg::*;
#(
  parameter int NUM = 16,
  parameter int IW  = $clog2(NUM)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] fetchReq,
  input  logic [NUM-1:0] execReq,
  input  logic [NUM-1:0] haltIn,
  input  logic           quantumTick,
  output logic           fetchValid,
  output logic [IW-1:0]  fetchStream,
  output logic           execValid,
  output logic [IW-1:0]  execStream
);

  ringStrobe_t   strobe;
  logic          topHalted;
  logic [IW-1:0] rotCount;

  ringarb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .quantumTick (quantumTick),
    .topHalted   (topHalted),
    .strobe      (strobe)
  );

  ringarb_ring #(.NUM(NUM), .IW(IW)) u_ring (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fetchReqIn  (fetchReq),
    .execReqIn   (execReq),
    .haltIn      (haltIn),
    .fetchValid  (fetchValid),
    .fetchStream (fetchStream),
    .execValid   (execValid),
    .execStream  (execStream),
    .topHalted   (topHalted),
    .rotCount    (rotCount)
  );

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rotate |=> rotCount == IW'($past(rotCount) + 1'b1)); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rotate |=> $stable(rotCount)); // R8

  AST_COMP_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (topHalted && !strobe.rotate) |=> (strobe.rotate || !topHalted)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.rotate, strobe.load}) == 1); // R9

endmodule

// File: tb/rot_ring_arbiter_tb.sv
module rot_ring_arbiter_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] fetchReq;
  logic [15:0] execReq;
  logic [15:0] haltIn;
  logic        quantumTick;
  logic        fetchValid;
  logic [3:0]  fetchStream;
  logic        execValid;
  logic [3:0]  execStream;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rot_ring_arbiter u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .fetchReq    (fetchReq),
    .execReq     (execReq),
    .haltIn      (haltIn),
    .quantumTick (quantumTick),
    .fetchValid  (fetchValid),
    .fetchStream (fetchStream),
    .execValid   (execValid),
    .execStream  (execStream)
  );

  // {fetchReq, execReq, expFetchValid, expFetchIdx, expExecValid, expExecIdx}
  localparam int NVEC = 6;
  localparam logic [41:0] VEC [NVEC] = '{
    {16'h0001, 16'h0000, 1'b1, 4'd0,  1'b0, 4'd0},
    {16'h8001, 16'h0100, 1'b1, 4'd15, 1'b1, 4'd8},
    {16'h0230, 16'h4002, 1'b1, 4'd9,  1'b1, 4'd14},
    {16'h0000, 16'hFFFF, 1'b0, 4'd0,  1'b1, 4'd15},
    {16'h00F0, 16'h0880, 1'b1, 4'd7,  1'b1, 4'd11},
    {16'h0000, 16'h0000, 1'b0, 4'd0,  1'b0, 4'd0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic av, input logic [3:0] ai,
                     input logic xv, input logic [3:0] xi);
    checks++;
    if (av !== xv || (xv && ai !== xi)) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               tag, av, ai, xv, xi);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fetchReq = '0; execReq = '0; haltIn = '0; quantumTick = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    doReset();
    // R1: nothing granted right after reset
    chk("R1 fetch after reset", fetchValid, fetchStream, 1'b0, 4'd0);
    chk("R1 exec after reset", execValid, execStream, 1'b0, 4'd0);

    // R2 / R3: table walk with count 0 and no halts
    for (int v = 0; v < NVEC; v++) begin
      fetchReq = VEC[v][41:26];
      execReq  = VEC[v][25:10];
      step();
      chk("R2 fetch table", fetchValid, fetchStream, VEC[v][9], VEC[v][8:5]);
      chk("R3 exec table", execValid, execStream, VEC[v][4], VEC[v][3:0]);
    end

    // R4: a halted stream below the top is never granted
    doReset();
    haltIn = 16'h0080; fetchReq = 16'h0088; execReq = 16'h0080;
    step();
    chk("R4 halted fetch skipped", fetchValid, fetchStream, 1'b1, 4'd3);
    chk("R4 halted exec masked", execValid, execStream, 1'b0, 4'd0);

    // R5 / R6: halted streams 15, 0 and 1 are skipped, one rotation per two cycles
    doReset();
    haltIn = 16'h8003; fetchReq = 16'hC004; execReq = 16'h4000;
    step();
    chk("R4 halted top not granted", fetchValid, fetchStream, 1'b1, 4'd14);
    step();
    chk("R5 first rotation", fetchValid, fetchStream, 1'b1, 4'd14);
    repeat (3) step();
    chk("R6 still skipping", fetchValid, fetchStream, 1'b1, 4'd14);
    step();
    chk("R5 skip complete", fetchValid, fetchStream, 1'b1, 4'd2);
    repeat (2) step();
    chk("R5 stays settled", fetchValid, fetchStream, 1'b1, 4'd2);
    chk("R3 exec under rotation", execValid, execStream, 1'b1, 4'd14);

    // R7 / R8: quantum ticks walk the top priority
    doReset();
    fetchReq = 16'h8008; execReq = 16'h8001;
    step();
    chk("R2 before ticks", fetchValid, fetchStream, 1'b1, 4'd15);
    for (int t = 0; t < 4; t++) begin
      quantumTick = 1'b1;
      step();
      quantumTick = 1'b0;
      step();
      step();
      if (t == 0) begin
        chk("R7 one tick fetch", fetchValid, fetchStream, 1'b1, 4'd15);
        chk("R7 one tick exec", execValid, execStream, 1'b1, 4'd0);
      end
    end
    chk("R8 four rotations fetch", fetchValid, fetchStream, 1'b1, 4'd3);
    chk("R8 four rotations exec", execValid, execStream, 1'b1, 4'd0);

    // R9: inputs changed during a rotation cycle are deferred
    doReset();
    fetchReq = 16'h0020;
    step();
    chk("R2 single request", fetchValid, fetchStream, 1'b1, 4'd5);
    quantumTick = 1'b1;
    step();
    quantumTick = 1'b0;
    fetchReq = 16'h0200;
    step();
    chk("R9 rotation ignores inputs", fetchValid, fetchStream, 1'b1, 4'd5);
    step();
    chk("R9 change applied after", fetchValid, fetchStream, 1'b1, 4'd9);

    finishRun();
  end

endmodule